// File: doc/BRIEF.md
# FIFO Level DMA Request Generator

This block sits next to the transmit and receive sample FIFOs of an audio serial port. It compares the current fill level of each FIFO with programmable thresholds and turns the result into DMA request lines. For each direction it drives a normal request and a more urgent panic request. It also produces the FIFO status flags, two sticky error flags and a set of interrupt lines, each masked by its own enable bit.

A transmit FIFO asks for data while it is running low. A receive FIFO asks to be drained while it is filling up. One configuration word holds all four 8-bit thresholds. A single DMA enable input gates every request line. Each FIFO has its own clear input, which is registered into a flush strobe for that FIFO alone. The FIFO memories and the DMA engine are outside this block.

Top module: `fifo_dreq_gen`

## Requirements
- R1: `thresh_cfg` holds four levels: bits [31:24] are the transmit panic level, [23:16] the receive panic level, [15:8] the transmit request level and [7:0] the receive request level. `tx_dreq` is high in the same cycle exactly when `dma_en` is 1 and `tx_level` is strictly below the transmit request level.
- R2: `rx_dreq` is high in the same cycle exactly when `dma_en` is 1 and `rx_level` is strictly above the receive request level.
- R3: `tx_panic` is high in the same cycle exactly when `dma_en` is 1 and `tx_level` is strictly below the transmit panic level.
- R4: `rx_panic` is high in the same cycle exactly when `dma_en` is 1 and `rx_level` is strictly above the receive panic level.
- R5: While `dma_en` is 0, all four request outputs are 0, whatever the levels are.
- R6: The combinational status flags are driven from the levels alone. `st_tx_empty` is 1 when `tx_level` is 0. `st_rx_data` is 1 when `rx_level` is nonzero. `st_rx_full` is 1 when `rx_level` equals DEPTH. `st_tx_want` is 1 when `tx_level` is below the transmit request level. `st_rx_ready` is 1 when `rx_level` is above the receive request level. None of these flags depends on `dma_en`.
- R7: `st_tx_err` and `st_rx_err` reset to 0. Each one goes to 1 on the clock edge after its event (`tx_underrun` or `rx_overrun`) is seen high. Each stays at 1 until an edge where its own clear input (`tx_err_w1c` or `rx_err_w1c`) is 1 and its event input is 0. If the event and the clear are high at the same edge, the flag ends at 1.
- R8: `irq[3]` equals `st_rx_err & irq_en[3]`. `irq[2]` equals `st_tx_err & irq_en[2]`. `irq[1]` equals `st_rx_ready & irq_en[1]`. `irq[0]` equals `st_tx_want & irq_en[0]`.
- R9: `tx_flush` is `tx_clr` delayed by one clock, and `rx_flush` is `rx_clr` delayed by one clock. Each clear input drives only its own flush output, and both flush outputs are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | Global DMA request enable |
| thresh_cfg | input | 32 | Packed thresholds (see R1) |
| irq_en | input | 4 | Interrupt enables (see R8) |
| tx_level | input | 7 | Transmit FIFO fill level |
| rx_level | input | 7 | Receive FIFO fill level |
| tx_underrun | input | 1 | Transmit underflow event |
| rx_overrun | input | 1 | Receive overflow event |
| tx_err_w1c | input | 1 | Write-one clear of transmit error |
| rx_err_w1c | input | 1 | Write-one clear of receive error |
| tx_clr | input | 1 | Transmit FIFO clear request |
| rx_clr | input | 1 | Receive FIFO clear request |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_panic | output | 1 | Transmit panic request |
| rx_panic | output | 1 | Receive panic request |
| st_tx_empty | output | 1 | Transmit FIFO empty |
| st_rx_data | output | 1 | Receive FIFO holds data |
| st_rx_full | output | 1 | Receive FIFO full |
| st_tx_want | output | 1 | Transmit needs writing |
| st_rx_ready | output | 1 | Receive needs reading |
| st_tx_err | output | 1 | Sticky transmit error |
| st_rx_err | output | 1 | Sticky receive error |
| irq | output | 4 | Masked interrupt lines |
| tx_flush | output | 1 | Transmit FIFO flush strobe |
| rx_flush | output | 1 | Receive FIFO flush strobe |

## Verification
Requests, level status and the interrupt lines follow their inputs in the same cycle. The bench therefore checks them after the new inputs have been driven at the falling edge and before the next rising edge. Error flags and flush strobes change one rising edge after their inputs. The reference model advances its own copies of those bits only just after each rising edge, so every comparison sees the correct cycle. Stimulus covers levels equal to a threshold, thresholds of 0 and 255, full and empty FIFOs, an event and a clear at the same edge, and clears of one FIFO while the other's clear stays low.

// File: rtl/fifo_dreq_gen.sv
module fifo_dreq_gen #(
  parameter int DEPTH = 64,
  parameter int LW    = 7,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic [4*TW-1:0] thresh_cfg,
  input  logic [3:0]    irq_en,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          tx_underrun,
  input  logic          rx_overrun,
  input  logic          tx_err_w1c,
  input  logic          rx_err_w1c,
  input  logic          tx_clr,
  input  logic          rx_clr,
  output logic          tx_dreq,
  output logic          rx_dreq,
  output logic          tx_panic,
  output logic          rx_panic,
  output logic          st_tx_empty,
  output logic          st_rx_data,
  output logic          st_rx_full,
  output logic          st_tx_want,
  output logic          st_rx_ready,
  output logic          st_tx_err,
  output logic          st_rx_err,
  output logic [3:0]    irq,
  output logic          tx_flush,
  output logic          rx_flush
);
  localparam int CW = ((LW > TW) ? LW : TW) + 1;

  logic [CW-1:0] txl, rxl, tx_pan_t, rx_pan_t, tx_req_t, rx_req_t;
  logic tx_low_pan, rx_high_pan;

  assign txl      = CW'(tx_level);
  assign rxl      = CW'(rx_level);
  assign tx_pan_t = CW'(thresh_cfg[4*TW-1:3*TW]);
  assign rx_pan_t = CW'(thresh_cfg[3*TW-1:2*TW]);
  assign tx_req_t = CW'(thresh_cfg[2*TW-1:TW]);
  assign rx_req_t = CW'(thresh_cfg[TW-1:0]);

  assign st_tx_want  = txl < tx_req_t;
  assign st_rx_ready = rxl > rx_req_t;
  assign tx_low_pan  = txl < tx_pan_t;
  assign rx_high_pan = rxl > rx_pan_t;

  assign tx_dreq  = dma_en & st_tx_want;
  assign rx_dreq  = dma_en & st_rx_ready;
  assign tx_panic = dma_en & tx_low_pan;
  assign rx_panic = dma_en & rx_high_pan;

  assign st_tx_empty = (tx_level == '0);
  assign st_rx_data  = (rx_level != '0);
  assign st_rx_full  = (rxl == CW'(DEPTH));

  assign irq = irq_en & {st_rx_err, st_tx_err, st_rx_ready, st_tx_want};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_tx_err <= 1'b0;
      st_rx_err <= 1'b0;
      tx_flush  <= 1'b0;
      rx_flush  <= 1'b0;
    end else begin
      st_tx_err <= tx_underrun | (st_tx_err & ~tx_err_w1c);
      st_rx_err <= rx_overrun  | (st_rx_err & ~rx_err_w1c);
      tx_flush  <= tx_clr;
      rx_flush  <= rx_clr;
    end
  end

  AST_REQ_OFF_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !(tx_dreq | rx_dreq | tx_panic | rx_panic)); // R5
  AST_TX_PANIC_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_panic && tx_pan_t <= tx_req_t) |-> tx_dreq); // R3
  AST_RX_PANIC_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_panic && rx_pan_t >= rx_req_t) |-> rx_dreq); // R4
  AST_TX_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> st_tx_err); // R7
  AST_RX_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rx_err && !rx_err_w1c) |=> st_rx_err); // R7
  AST_FLUSH_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr && !rx_clr) |=> (tx_flush && !rx_flush)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~irq_en) == 4'b0); // R8
endmodule

// File: tb/fifo_dreq_gen_test.sv
module fifo_dreq_gen_test;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_en = 1'b0;
  logic [31:0] thresh_cfg = '0;
  logic [3:0] irq_en = '0;
  logic [6:0] tx_level = '0, rx_level = '0;
  logic tx_underrun = 1'b0, rx_overrun = 1'b0;
  logic tx_err_w1c = 1'b0, rx_err_w1c = 1'b0;
  logic tx_clr = 1'b0, rx_clr = 1'b0;
  logic tx_dreq, rx_dreq, tx_panic, rx_panic;
  logic st_tx_empty, st_rx_data, st_rx_full, st_tx_want, st_rx_ready;
  logic st_tx_err, st_rx_err, tx_flush, rx_flush;
  logic [3:0] irq;

  int checks = 0;
  int fails  = 0;
  int m_txe = 0, m_rxe = 0, m_txf = 0, m_rxf = 0;

  always #2 clk = ~clk;

  fifo_dreq_gen #(.DEPTH(DEPTH), .LW(7), .TW(8)) uut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .thresh_cfg(thresh_cfg),
    .irq_en(irq_en), .tx_level(tx_level), .rx_level(rx_level),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun),
    .tx_err_w1c(tx_err_w1c), .rx_err_w1c(rx_err_w1c),
    .tx_clr(tx_clr), .rx_clr(rx_clr),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .tx_panic(tx_panic), .rx_panic(rx_panic),
    .st_tx_empty(st_tx_empty), .st_rx_data(st_rx_data), .st_rx_full(st_rx_full),
    .st_tx_want(st_tx_want), .st_rx_ready(st_rx_ready),
    .st_tx_err(st_tx_err), .st_rx_err(st_rx_err), .irq(irq),
    .tx_flush(tx_flush), .rx_flush(rx_flush));

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int tl, rl, tpan, rpan, treq, rreq, want, rdy, de;
    string dt;
    tl = int'(tx_level); rl = int'(rx_level);
    tpan = int'(thresh_cfg[31:24]); rpan = int'(thresh_cfg[23:16]);
    treq = int'(thresh_cfg[15:8]);  rreq = int'(thresh_cfg[7:0]);
    de = dma_en ? 1 : 0;
    dt = dma_en ? "" : "R5";
    want = (tl < treq) ? 1 : 0;
    rdy  = (rl > rreq) ? 1 : 0;
    chk({"R1 ", dt}, "tx_dreq",  int'(tx_dreq),  de & want);
    chk({"R2 ", dt}, "rx_dreq",  int'(rx_dreq),  de & rdy);
    chk({"R3 ", dt}, "tx_panic", int'(tx_panic), de & ((tl < tpan) ? 1 : 0));
    chk({"R4 ", dt}, "rx_panic", int'(rx_panic), de & ((rl > rpan) ? 1 : 0));
    chk("R6", "st_tx_empty", int'(st_tx_empty), (tl == 0) ? 1 : 0);
    chk("R6", "st_rx_data",  int'(st_rx_data),  (rl != 0) ? 1 : 0);
    chk("R6", "st_rx_full",  int'(st_rx_full),  (rl == DEPTH) ? 1 : 0);
    chk("R6", "st_tx_want",  int'(st_tx_want),  want);
    chk("R6", "st_rx_ready", int'(st_rx_ready), rdy);
    chk("R7", "st_tx_err", int'(st_tx_err), m_txe);
    chk("R7", "st_rx_err", int'(st_rx_err), m_rxe);
    chk("R8", "irq", int'(irq),
        int'(irq_en) & ((m_rxe << 3) | (m_txe << 2) | (rdy << 1) | want));
    chk("R9", "tx_flush", int'(tx_flush), m_txf);
    chk("R9", "rx_flush", int'(rx_flush), m_rxf);
  endtask

  task automatic step();
    int n_txe, n_rxe;
    #1;
    compare_all();
    n_txe = (tx_underrun || (m_txe != 0 && !tx_err_w1c)) ? 1 : 0;
    n_rxe = (rx_overrun  || (m_rxe != 0 && !rx_err_w1c)) ? 1 : 0;
    @(posedge clk);
    #1;
    m_txe = n_txe; m_rxe = n_rxe;
    m_txf = tx_clr ? 1 : 0; m_rxf = rx_clr ? 1 : 0;
    @(negedge clk);
  endtask

  task automatic idle_events();
    tx_underrun = 0; rx_overrun = 0; tx_err_w1c = 0; rx_err_w1c = 0;
    tx_clr = 0; rx_clr = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tx_underrun = 1; rx_overrun = 1; tx_clr = 1; rx_clr = 1;
    #1;
    chk("R7", "reset st_tx_err", int'(st_tx_err), 0);
    chk("R7", "reset st_rx_err", int'(st_rx_err), 0);
    chk("R9", "reset tx_flush", int'(tx_flush), 0);
    chk("R9", "reset rx_flush", int'(rx_flush), 0);
    idle_events();
    @(negedge clk);
    rst_n = 1;

    // R1 R2 R3 R4: thresholds tx_pan=8 rx_pan=48 tx_req=32 rx_req=16
    thresh_cfg = {8'd8, 8'd48, 8'd32, 8'd16};
    dma_en = 1; irq_en = 4'hF;
    for (int i = 0; i <= DEPTH; i += 4) begin
      tx_level = 7'(i); rx_level = 7'(DEPTH - i); step();
    end
    // boundaries: levels equal to thresholds
    tx_level = 7'd32; rx_level = 7'd16; step();
    tx_level = 7'd8;  rx_level = 7'd48; step();
    tx_level = 7'd31; rx_level = 7'd17; step();
    tx_level = 7'd7;  rx_level = 7'd49; step();
    // R5: dma disabled
    dma_en = 0;
    tx_level = 0; rx_level = 7'(DEPTH); step();
    dma_en = 1; step();
    // thresholds 0 and 255
    thresh_cfg = {8'd0, 8'd255, 8'd0, 8'd255}; step();
    thresh_cfg = {8'd255, 8'd0, 8'd255, 8'd0}; tx_level = 7'(DEPTH); rx_level = 1; step();
    // R7: errors sticky and write-one clear
    thresh_cfg = {8'd8, 8'd48, 8'd32, 8'd16};
    irq_en = 4'b1100;
    tx_underrun = 1; step(); idle_events();
    step(); step();
    rx_overrun = 1; step(); idle_events(); step();
    rx_err_w1c = 1; step(); idle_events(); step();
    tx_err_w1c = 1; tx_underrun = 1; step(); idle_events(); step();
    tx_err_w1c = 1; step(); idle_events(); step();
    // R9: separate clears
    tx_clr = 1; step(); idle_events(); step();
    rx_clr = 1; step(); idle_events(); step();
    tx_clr = 1; rx_clr = 1; step(); idle_events(); step();
    // R8: each enable bit alone
    for (int b = 0; b < 4; b++) begin
      irq_en = 4'(1 << b); tx_underrun = 1; rx_overrun = 1;
      tx_level = 3; rx_level = 40; step(); idle_events(); step();
    end
    // mixed pseudo-random stimulus
    for (int k = 0; k < 400; k++) begin
      tx_level = 7'($urandom_range(0, DEPTH));
      rx_level = 7'($urandom_range(0, DEPTH));
      if (k % 50 == 0) thresh_cfg = $urandom();
      dma_en = ($urandom_range(0, 3) != 0);
      irq_en = 4'($urandom());
      tx_underrun = ($urandom_range(0, 9) == 0);
      rx_overrun  = ($urandom_range(0, 9) == 0);
      tx_err_w1c  = ($urandom_range(0, 4) == 0);
      rx_err_w1c  = ($urandom_range(0, 4) == 0);
      tx_clr = ($urandom_range(0, 5) == 0);
      rx_clr = ($urandom_range(0, 5) == 0);
      step();
    end
    idle_events(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule